// File: doc/BRIEF.md
# Display serial interface controller

This block drives a small display panel over a serial display bus. A host issues one request at a time: a command write (an optional command byte followed by parameter bytes), a frame-data write (parameter bytes only), a read (command bytes followed by bytes clocked back from the panel) or a panel reset pulse. The bytes that go out after the command byte come from a valid/ready byte stream. Bytes read back leave on `rx_data`, each marked by a one-cycle `rx_valid`.

Two wirings are supported. In 3-wire mode the command/data flag is carried on the data line itself as the first bit of a 9-bit word, and the D/C pin is not used. In 4-wire mode every word is 8 bits and the D/C pin carries the flag. The bus runs in SPI mode 0: MOSI changes while SCK is low and MISO is sampled on the rising SCK edge. Each SCK half period lasts `DIV` system clocks.

Top module: `panel_link_ctrl`

## Requirements
- R1: After reset `cs_n`=1, `sck`=0, `panel_rst`=0, `busy`=0 and `done`=0.
- R2: In 3-wire mode (`req_mode`=0) each written word is 9 bits, sent MSB first. The first bit is the flag: 0 for a command byte and 1 for a data byte. The 8 byte bits follow it.
- R3: A command write (`req_op`=0) sends the command byte first when `req_cmd_en`=1, then `req_txlen` stream bytes, each as its own data word. A frame write (`req_op`=1) sends only the `req_txlen` stream bytes and never the command byte.
- R4: In 4-wire mode (`req_mode`=1) each word is 8 bits, MSB first. `dc` is 0 while a command byte is shifted and 1 while a data byte or a read byte is shifted.
- R5: During writes, chip select is released (`cs_n` goes high) after every word in 3-wire mode. In 4-wire mode it is released between the command byte and the data bytes, and all data bytes of one request go out under a single chip-select assertion. No release happens part-way through a word.
- R6: A read (`req_op`=2) sends `req_txlen` stream bytes as command words, then receives `req_rxlen` 8-bit words. The read words carry no flag bit, and MOSI is held at 0 while they are clocked. Each received byte, assembled MSB first, appears on `rx_data` with a one-cycle `rx_valid`.
- R7: During a read, `cs_n` stays low without a break from the first command word to the last received word.
- R8: SCK idles low whenever no word is being shifted. MOSI never changes while SCK is high. Each SCK high phase lasts `DIV` clocks.
- R9: A reset request (`req_op`=3) with `rst_present`=1 holds `panel_rst` high for `reset_ticks` clocks, where 0 counts as 1, then releases it and pulses `done` with `err`=0.
- R10: A reset request with `rst_present`=0 pulses `done` with `err`=1 and leaves `panel_rst` low.
- R11: A bus request with `req_mode` of 2 or 3 pulses `done` with `err`=1 and never asserts `cs_n`.
- R12: `busy` is high from the cycle after a request is accepted until the request ends, and `done` is a single-cycle pulse at the end. A `req_valid` seen while busy is ignored: it causes no bus traffic and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 command write, 1 frame write, 2 read, 3 panel reset |
| req_mode | input | 2 | 0 three-wire, 1 four-wire, 2 and 3 unsupported |
| req_cmd_en | input | 1 | Command byte present (command write) |
| req_cmd | input | 8 | Command byte |
| req_txlen | input | LEN_W | Stream bytes to send |
| req_rxlen | input | LEN_W | Bytes to read back |
| reset_ticks | input | RST_W | Panel reset pulse length in clocks |
| rst_present | input | 1 | Panel reset pin is fitted |
| tx_data | input | 8 | Outgoing stream byte |
| tx_valid | input | 1 | Stream byte available |
| tx_ready | output | 1 | Stream byte consumed this cycle when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request rejected, valid with done |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to panel |
| miso | input | 1 | Serial data from panel |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Command/data pin (4-wire) |
| panel_rst | output | 1 | Panel reset, active high |

## Verification
The assertions assume that request fields matter only in the cycle `req_valid` is seen while idle, that `DIV` is at least 2, and that `tx_valid` may be low at any time without breaking word framing. The bench loads the stream queue before each request, so stream bytes are always available. It holds request fields steady for exactly one strobe cycle and drives MISO from a function of the SCK rise count, so the panel's side changes only after the rising edge the controller samples. The single out-of-bounds stimulus is deliberate: a second strobe issued while busy, to exercise the ignore rule.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_FRAME = 2'd1,
    OP_READ  = 2'd2,
    OP_RESET = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP
  } state_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_DATA,
    PH_RCMD,
    PH_RX
  } phase_e;

  // Only codes 0 (three-wire) and 1 (four-wire) are carried out.
  function automatic logic mode_ok(logic [1:0] m);
    return (m == 2'd0) || (m == 2'd1);
  endfunction

  // Word placed left-aligned in 9 bits so that bit 8 always leaves first.
  function automatic logic [8:0] pack_word(logic four_wire, logic flag, logic [7:0] b);
    return four_wire ? {b, 1'b0} : {flag, b};
  endfunction

  // Three-wire writes carry the flag bit; everything else is a plain byte.
  function automatic logic [3:0] word_bits(logic four_wire, logic is_rx);
    return (four_wire || is_rx) ? 4'd8 : 4'd9;
  endfunction

endpackage

// File: rtl/plc_sck_div.sv
module plc_sck_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign tick = run && (cnt == LAST);

  initial begin
    assert (DIV >= 2) else $error("DIV below 2");
  end
endmodule

// File: rtl/plc_shifter.sv
module plc_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] nbits,
  input  logic [8:0] word,
  input  logic       drive,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic       active;
  logic       drv;
  logic [3:0] bits_left;
  logic [8:0] sreg;
  logic       half_tick;
  logic       last_fall;

  plc_sck_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .tick (half_tick)
  );

  assign last_fall = active && half_tick && sck && (bits_left == 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      drv       <= 1'b0;
      sck       <= 1'b0;
      bits_left <= '0;
      sreg      <= '0;
      rx_byte   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active    <= 1'b1;
        sck       <= 1'b0;
        sreg      <= word;
        bits_left <= nbits;
        drv       <= drive;
      end else if (active && half_tick) begin
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (last_fall) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bits_left <= bits_left - 4'd1;
            sreg      <= {sreg[7:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi = active && drv && sreg[8];

  // R8: data line holds still through every high phase of the clock
  p_mosi_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R8: clock idles low outside a word
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck);

  // R8: a finished word leaves the clock low
  p_done_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sck && !active));
endmodule

// File: rtl/plc_rst_timer.sv
module plc_rst_timer #(
  parameter int RST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RST_W-1:0] ticks,
  output logic             pin,
  output logic             fin
);
  logic [RST_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
      fin <= 1'b0;
      cnt <= '0;
    end else begin
      fin <= 1'b0;
      if (start && !pin) begin
        pin <= 1'b1;
        cnt <= (ticks == '0) ? RST_W'(1) : ticks;
      end else if (pin) begin
        if (cnt <= RST_W'(1)) begin
          pin <= 1'b0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt - RST_W'(1);
        end
      end
    end
  end

  // R9: the pulse ends exactly when the count runs out
  p_fin_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!pin && $past(pin)));
endmodule

// File: rtl/panel_link_ctrl.sv
module panel_link_ctrl
  import plc_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int LEN_W = 8,
  parameter int RST_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [1:0]       req_mode,
  input  logic             req_cmd_en,
  input  logic [7:0]       req_cmd,
  input  logic [LEN_W-1:0] req_txlen,
  input  logic [LEN_W-1:0] req_rxlen,
  input  logic [RST_W-1:0] reset_ticks,
  input  logic             rst_present,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             dc,
  output logic             panel_rst
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  state_e           state;
  phase_e           phase;
  op_e              op_q;
  logic             four_q;
  logic [7:0]       cmd_q;
  logic [LEN_W-1:0] tx_left;
  logic [LEN_W-1:0] rx_left;

  // named internal events
  logic       accept;
  logic       need_byte;
  logic       is_rx_ph;
  logic       load_fire;
  logic       word_end;
  logic       rt_start;
  logic       rt_fin;
  logic [7:0] sh_rx;
  logic [7:0] byte_sel;
  logic [8:0] sh_word;
  logic [3:0] sh_nbits;
  logic       sh_drive;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign need_byte = (phase == PH_DATA) || (phase == PH_RCMD);
  assign is_rx_ph  = (phase == PH_RX);
  assign load_fire = (state == ST_LOAD) && (!need_byte || tx_valid);
  assign tx_ready  = (state == ST_LOAD) && need_byte;
  assign rt_start  = accept && (op_e'(req_op) == OP_RESET) && rst_present;

  assign byte_sel = (phase == PH_CMD) ? cmd_q : (is_rx_ph ? 8'h00 : tx_data);
  assign sh_word  = pack_word(four_q, phase == PH_DATA, byte_sel);
  assign sh_nbits = word_bits(four_q, is_rx_ph);
  assign sh_drive = !(is_rx_ph && !four_q);

  plc_shifter #(.DIV(DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (load_fire),
    .nbits  (sh_nbits),
    .word   (sh_word),
    .drive  (sh_drive),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .done   (word_end),
    .rx_byte(sh_rx)
  );

  plc_rst_timer #(.RST_W(RST_W)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .start(rt_start),
    .ticks(reset_ticks),
    .pin  (panel_rst),
    .fin  (rt_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_CMD;
      op_q     <= OP_WRITE;
      four_q   <= 1'b0;
      cmd_q    <= '0;
      tx_left  <= '0;
      rx_left  <= '0;
      cs_n     <= 1'b1;
      dc       <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_e'(req_op);
            four_q  <= req_mode[0];
            cmd_q   <= req_cmd;
            tx_left <= req_txlen;
            rx_left <= req_rxlen;
            if (op_e'(req_op) == OP_RESET) begin
              if (rst_present) begin
                state <= ST_RESET;
              end else begin
                done <= 1'b1;
                err  <= 1'b1;
              end
            end else if (!mode_ok(req_mode)) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              unique case (op_e'(req_op))
                OP_WRITE: begin
                  if (req_cmd_en) begin
                    phase <= PH_CMD;
                    state <= ST_LOAD;
                  end else if (req_txlen != '0) begin
                    phase <= PH_DATA;
                    state <= ST_LOAD;
                  end else begin
                    done <= 1'b1;
                  end
                end
                OP_FRAME: begin
                  if (req_txlen != '0) begin
                    phase <= PH_DATA;
                    state <= ST_LOAD;
                  end else begin
                    done <= 1'b1;
                  end
                end
                default: begin
                  if (req_txlen != '0) begin
                    phase <= PH_RCMD;
                    state <= ST_LOAD;
                  end else if (req_rxlen != '0) begin
                    phase <= PH_RX;
                    state <= ST_LOAD;
                  end else begin
                    done <= 1'b1;
                  end
                end
              endcase
            end
          end
        end
        ST_RESET: begin
          if (rt_fin) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          if (load_fire) begin
            cs_n  <= 1'b0;
            dc    <= four_q ? ((phase == PH_DATA) || is_rx_ph) : 1'b1;
            state <= ST_SHIFT;
            if (need_byte) tx_left <= tx_left - ONE;
            if (is_rx_ph)  rx_left <= rx_left - ONE;
          end
        end
        ST_SHIFT: begin
          if (word_end) begin
            if (is_rx_ph) begin
              rx_valid <= 1'b1;
              rx_data  <= sh_rx;
            end
            unique case (phase)
              PH_CMD: begin
                if (tx_left != '0) begin
                  phase <= PH_DATA;
                  cs_n  <= 1'b1;
                  state <= ST_GAP;
                end else begin
                  cs_n  <= 1'b1;
                  dc    <= 1'b1;
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end
              end
              PH_DATA: begin
                if (tx_left != '0) begin
                  if (!four_q) begin
                    cs_n  <= 1'b1;
                    state <= ST_GAP;
                  end else begin
                    state <= ST_LOAD;
                  end
                end else begin
                  cs_n  <= 1'b1;
                  dc    <= 1'b1;
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end
              end
              PH_RCMD: begin
                if (tx_left != '0) begin
                  state <= ST_LOAD;
                end else if (rx_left != '0) begin
                  phase <= PH_RX;
                  state <= ST_LOAD;
                end else begin
                  cs_n  <= 1'b1;
                  dc    <= 1'b1;
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end
              end
              default: begin
                if (rx_left != '0) begin
                  state <= ST_LOAD;
                end else begin
                  cs_n  <= 1'b1;
                  dc    <= 1'b1;
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end
              end
            endcase
          end
        end
        default: begin
          state <= ST_LOAD;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R1: chip select is released whenever nothing is running
  p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> cs_n);

  // R12: completion strobe lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: a strobe while busy leaves the latched request untouched
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(op_q) && $stable(four_q) && $stable(cmd_q)));

  // R11: a rejected request never touches the bus
  p_err_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy && done));

  // R10: no pin means no pulse
  p_no_pin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_e'(req_op) == OP_RESET && !rst_present) |=> !panel_rst);

  // R7: once a read has chip select low it stays low until completion
  p_read_cs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_READ && !cs_n) |=> (!cs_n || done));

  // R4: four-wire command words go out with the flag pin low
  p_dc_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && four_q && (phase == PH_CMD || phase == PH_RCMD)) |-> !dc);

  // R5: chip select only rises at a word boundary
  p_cs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(word_end));
endmodule

// File: tb/panel_link_ctrl_tb.sv
module panel_link_ctrl_tb;
  localparam int DIV   = 4;
  localparam int LEN_W = 8;
  localparam int RST_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [1:0]       req_op = '0;
  logic [1:0]       req_mode = '0;
  logic             req_cmd_en = 1'b0;
  logic [7:0]       req_cmd = '0;
  logic [LEN_W-1:0] req_txlen = '0;
  logic [LEN_W-1:0] req_rxlen = '0;
  logic [RST_W-1:0] reset_ticks = '0;
  logic             rst_present = 1'b1;
  logic [7:0]       tx_data = '0;
  logic             tx_valid = 1'b0;
  logic             tx_ready;
  logic [7:0]       rx_data;
  logic             rx_valid;
  logic             busy, done, err, sck, mosi, cs_n, dc, panel_rst;
  logic             miso;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int         nb;
    logic [8:0] w;
    logic       dcv;
    bit         chk_dc;
    bit         rx;
  } item_t;

  item_t      expq[$];
  string      tagq[$];
  logic [7:0] txq[$];
  logic [7:0] rxexp[$];

  int  rise_cnt = 0;
  int  acc = 0;
  int  cap = 0;
  int  rcap = 0;
  int  cs_rel = 0;
  int  cs_fall = 0;
  int  done_cnt = 0;
  bit  err_seen = 0;
  bit  mon_on = 0;
  int  hi_run = 0;
  int  hi_bad = 0;
  int  hi_seen = 0;
  int  rst_hi = 0;

  panel_link_ctrl #(.DIV(DIV), .LEN_W(LEN_W), .RST_W(RST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_mode(req_mode), .req_cmd_en(req_cmd_en), .req_cmd(req_cmd),
    .req_txlen(req_txlen), .req_rxlen(req_rxlen), .reset_ticks(reset_ticks),
    .rst_present(rst_present), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .done(done), .err(err), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .dc(dc), .panel_rst(panel_rst)
  );

  function automatic bit panel_bit(int c);
    return bit'(((c >> 0) ^ (c >> 2) ^ (c >> 3)) & 1);
  endfunction

  assign miso = panel_bit(rise_cnt);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // byte stream source
  always @(posedge clk) begin
    if (tx_ready && tx_valid && txq.size() > 0) void'(txq.pop_front());
    tx_valid <= (txq.size() > 0);
    tx_data  <= (txq.size() > 0) ? txq[0] : 8'h00;
  end

  // serial-side monitor: pops expected words and compares
  always @(posedge sck) begin
    if (mon_on && !cs_n) begin
      cap  = ((cap << 1) | int'(mosi)) & 9'h1FF;
      rcap = ((rcap << 1) | int'(panel_bit(rise_cnt))) & 8'hFF;
      rise_cnt++;
      acc++;
      if (expq.size() == 0) begin
        check(0, "R12 unexpected serial bit", acc, 0);
        acc = 0;
      end else begin
        if (acc == 1 && expq[0].chk_dc)
          check(dc == expq[0].dcv, {tagq[0], " dc level"}, int'(dc), int'(expq[0].dcv));
        if (acc == expq[0].nb) begin
          if (expq[0].nb == 8)
            check((cap & 8'hFF) == int'(expq[0].w[7:0]), tagq[0], cap & 8'hFF, int'(expq[0].w[7:0]));
          else
            check(cap == int'(expq[0].w), tagq[0], cap, int'(expq[0].w));
          if (expq[0].rx) rxexp.push_back(rcap[7:0]);
          void'(expq.pop_front());
          void'(tagq.pop_front());
          acc = 0;
          cap = 0;
          rcap = 0;
        end
      end
    end
  end

  always @(posedge cs_n) begin
    if (mon_on) begin
      cs_rel++;
      if (acc != 0) begin
        check(0, "R5 chip select released inside a word", acc, 0);
        acc = 0;
      end
    end
  end

  always @(negedge cs_n) if (mon_on) cs_fall++;

  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        done_cnt++;
        err_seen = err;
      end
      if (rx_valid) begin
        if (rxexp.size() == 0) check(0, "R6 read strobe with no read word", int'(rx_data), 0);
        else check(rx_data == rxexp.pop_front(), "R6 received byte", int'(rx_data), 0);
      end
      if (sck) hi_run++;
      else if (hi_run != 0) begin
        hi_seen++;
        if (hi_run != DIV) hi_bad++;
        hi_run = 0;
      end
      if (panel_rst) rst_hi++;
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 29 + i * 37 + 5) & 8'hFF);
  endfunction

  task automatic push_item(int nb, logic [8:0] w, logic dcv, bit chk, bit rx, string tag);
    item_t it;
    it.nb = nb; it.w = w; it.dcv = dcv; it.chk_dc = chk; it.rx = rx;
    expq.push_back(it);
    tagq.push_back(tag);
  endtask

  task automatic run_bus(input logic [1:0] op, input logic [1:0] mode, input bit ce,
                         input logic [7:0] cmd, input int ntx, input int nrx,
                         input bit exp_err, input int exp_rel, input bit inject,
                         input string tag);
    bit four;
    four = (mode == 2'd1);
    if (!exp_err) begin
      if (op == 2'd0 && ce)
        push_item(four ? 8 : 9, four ? {1'b0, cmd} : {1'b0, cmd}, 1'b0, four, 0,
                  four ? "R4 command word" : "R2 command word");
      for (int i = 0; i < ntx; i++) begin
        logic [7:0] b;
        b = pat(int'(cmd), i);
        txq.push_back(b);
        if (op == 2'd2)
          push_item(four ? 8 : 9, {1'b0, b}, 1'b0, four, 0, "R6 read command word");
        else
          push_item(four ? 8 : 9, four ? {1'b0, b} : {1'b1, b}, 1'b1, four, 0,
                    four ? "R4 data word" : "R3 data word");
      end
      if (op == 2'd2)
        for (int i = 0; i < nrx; i++)
          push_item(8, 9'h000, 1'b1, four, 1, "R6 read word mosi idle");
    end
    cs_rel = 0; cs_fall = 0; done_cnt = 0; hi_bad = 0; hi_seen = 0;
    @(negedge clk);
    req_op = op; req_mode = mode; req_cmd_en = ce; req_cmd = cmd;
    req_txlen = LEN_W'(ntx); req_rxlen = LEN_W'(nrx); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == !exp_err, {tag, " R12 busy after accept"}, int'(busy), int'(!exp_err));
    if (inject) begin
      repeat (30) @(negedge clk);
      req_op = 2'd2; req_mode = 2'd1; req_txlen = 3; req_rxlen = 2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(err_seen == exp_err, {tag, " err flag"}, int'(err_seen), int'(exp_err));
    check(done_cnt == 1, {tag, " R12 single done"}, done_cnt, 1);
    check(expq.size() == 0, {tag, " all words seen"}, expq.size(), 0);
    check(rxexp.size() == 0, {tag, " R6 all read bytes delivered"}, rxexp.size(), 0);
    check(cs_rel == exp_rel, {tag, " chip select releases"}, cs_rel, exp_rel);
    if (exp_err) check(cs_fall == 0, {tag, " R11 no chip select"}, cs_fall, 0);
    else check(hi_seen > 0 && hi_bad == 0, {tag, " R8 clock high width"}, hi_bad, 0);
    check(!busy && cs_n && !sck, {tag, " back to idle"}, int'({busy, cs_n, sck}), 3'b010);
    expq.delete(); tagq.delete(); txq.delete(); rxexp.delete();
  endtask

  task automatic run_reset(input int ticks, input bit present, input string tag);
    int exp_hi;
    exp_hi = present ? ((ticks == 0) ? 1 : ticks) : 0;
    done_cnt = 0; rst_hi = 0; cs_fall = 0;
    @(negedge clk);
    req_op = 2'd3; req_mode = 2'd3; reset_ticks = RST_W'(ticks);
    rst_present = present; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rst_hi == exp_hi, {tag, " reset pulse length"}, rst_hi, exp_hi);
    check(err_seen == !present, {tag, " reset err"}, int'(err_seen), int'(!present));
    check(done_cnt == 1 && cs_fall == 0, {tag, " reset done once, bus quiet"}, done_cnt, 1);
    rst_present = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n at reset", int'(cs_n), 1);
    check(sck == 1'b0, "R1 sck at reset", int'(sck), 0);
    check(panel_rst == 1'b0, "R1 panel_rst at reset", int'(panel_rst), 0);
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done at reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_on = 1;

    run_bus(2'd0, 2'd0, 1, 8'h2A, 3, 0, 0, 4, 0, "R2 R3 R5 3w write");
    run_bus(2'd1, 2'd0, 1, 8'h2C, 2, 0, 0, 2, 0, "R3 3w frame write");
    run_bus(2'd0, 2'd1, 1, 8'hB1, 4, 0, 0, 2, 0, "R4 R5 4w write");
    run_bus(2'd1, 2'd1, 0, 8'h5E, 3, 0, 0, 1, 0, "R4 R5 4w frame write");
    run_bus(2'd2, 2'd0, 0, 8'h0A, 1, 2, 0, 1, 0, "R6 R7 3w read");
    run_bus(2'd2, 2'd1, 0, 8'h09, 2, 3, 0, 1, 0, "R6 R7 4w read");
    run_bus(2'd0, 2'd2, 1, 8'h11, 2, 0, 1, 0, 0, "R11 mode 2");
    run_bus(2'd2, 2'd3, 0, 8'h12, 1, 1, 1, 0, 0, "R11 mode 3");
    run_bus(2'd0, 2'd0, 1, 8'h77, 2, 0, 0, 3, 1, "R12 strobe while busy");
    run_reset(10, 1, "R9 ten ticks");
    run_reset(0, 1, "R9 zero ticks");
    run_reset(7, 0, "R10 pin absent");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule